// File: doc/BRIEF.md
# Packed SIMD Multiply Unit

This block is a pipelined multiply engine for a signal-processing datapath. On each cycle it may accept one operation: two 32-bit operands and a 4-bit operation code. The code selects one of eleven forms. These are a full-width 32x32 product with a choice of operand signedness, two independent 16x16 products, the sum or the difference of those two products, four 8x8 products, the sum of the four byte products, a complex multiply, a rounded and saturated complex multiply, and four parallel multiplies in GF(2^8).

Every result is 64 bits wide. Bits [31:0] form the half meant for the first destination register, and bits [63:32] form the half meant for the second. Each result appears two clock edges after its operands are taken, and it carries a valid flag. A small configuration register holds the low eight bits of the field polynomial used by the GF(2^8) lanes. The x^8 term is implied and is not stored. The unit takes its asynchronous active-low reset through an internal two-flop release synchronizer.

Top module: `simd_mul_unit`

## Requirements
- R1: An operation sampled with `in_valid` high at a rising edge appears on `out_res` with `out_valid` high after the second rising edge that follows. `out_valid` is low whenever no operation was sampled two edges earlier.
- R2: Opcodes 0, 1 and 2 produce the full 64-bit product of `in_a` and `in_b`. Opcode 0 treats both operands as signed. Opcode 1 treats both as unsigned. Opcode 2 treats `in_a` as signed and `in_b` as unsigned.
- R3: Opcode 3 produces two signed 16x16 products. The product of bits [15:0] of each operand is placed in bits [31:0] of the result. The product of bits [31:16] of each operand is placed in bits [63:32].
- R4: Opcode 4 returns the exact sum of the two signed 16-bit lane products, sign-extended to 64 bits. Opcode 5 returns the upper-lane product minus the lower-lane product, sign-extended to 64 bits.
- R5: Opcode 6 produces four unsigned 8x8 products. The product for byte lane k (bits [8k+7:8k] of each operand) is placed in result bits [16k+15:16k].
- R6: Opcode 7 returns the sum of the four unsigned byte-lane products, zero-extended to 64 bits.
- R7: Opcode 8 is a complex multiply. Each operand holds a signed 16-bit real part in bits [31:16] and a signed 16-bit imaginary part in bits [15:0]. Result bits [63:32] hold ar*br - ai*bi, and bits [31:0] hold ar*bi + ai*br, each taken modulo 2^32.
- R8: Opcode 9 computes the same real and imaginary sums as R7. For each sum it adds 2^15 and takes bits [31:16], saturating to 0x7FFF or 0x8000 when the value falls outside the signed 16-bit range. The real part goes to result bits [31:16], the imaginary part to bits [15:0], and bits [63:32] are zero.
- R9: Opcode 10 multiplies each byte lane of `in_a` by the same lane of `in_b` in GF(2^8). The reduction polynomial is x^8 plus the polynomial register. The four lane results go to result bits [31:0] in lane order, and bits [63:32] are zero. The polynomial register resets to 0x1D. It takes `poly_wdata` at a rising edge when `poly_we` is high, and it holds its value otherwise. A written value applies to operations sampled at later edges.
- R10: Opcodes 11 to 15 return zero. `out_res` holds its last value in every cycle that carries no new result, whatever happens on the operand inputs.
- R11: While reset is asserted, and until the first result, `out_valid` is low and `out_res` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| poly_we | input | 1 | Write strobe for the GF(2^8) polynomial register |
| poly_wdata | input | 8 | New polynomial value, without the x^8 term |
| out_valid | output | 1 | `out_res` carries a new result |
| out_res | output | 64 | Result: [31:0] first destination, [63:32] second |

## Verification
The full-width products are driven with a negative operand against an operand whose top bit is set. That one pattern gives three different answers under the three signedness modes, so a swapped sign-extension shows up at once. The lane forms use operands whose lanes all differ and include 0x8000 and 0xFF values, which exposes swapped lanes, a lost carry in the sums and wrap-around in the 16-bit dot products. The complex forms include the case where every part is -32768: the wrapped imaginary part reads 0x80000000 there, while the rounded form must saturate to 0x7FFF. A small-value case checks the rounding direction. The GF lanes are run once with the reset polynomial and once after a write, on bytes whose products differ under the two polynomials, and the results are checked against a reference that multiplies without carries and then reduces.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

  typedef enum logic [3:0] {
    OP_MUL_SS    = 4'd0,
    OP_MUL_UU    = 4'd1,
    OP_MUL_SU    = 4'd2,
    OP_DUAL16    = 4'd3,
    OP_DOT16_ADD = 4'd4,
    OP_DOT16_SUB = 4'd5,
    OP_QUAD8     = 4'd6,
    OP_DOT8      = 4'd7,
    OP_CMPY      = 4'd8,
    OP_CMPY_RND  = 4'd9,
    OP_GF8       = 4'd10
  } mul_op_e;

  localparam int unsigned OP_W    = 4;
  localparam int unsigned GF_W    = 8;
  localparam logic [7:0]  GF_POLY_RESET = 8'h1D;

endpackage

// File: rtl/simd_mul_gf8.sv
module simd_mul_gf8 #(
  parameter int unsigned LW = 8
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  logic [LW-1:0] poly_i,
  output logic [LW-1:0] p_o
);

  logic [LW-1:0] acc;
  logic [LW-1:0] sh;
  logic          carry;

  // Shift-and-add: walk the multiplier bits and reduce the multiplicand
  // after every doubling.
  always_comb begin
    acc = '0;
    sh  = a_i;
    for (int i = 0; i < LW; i++) begin
      if (b_i[i]) acc = acc ^ sh;
      carry = sh[LW-1];
      sh    = sh << 1;
      if (carry) sh = sh ^ poly_i;
    end
    p_o = acc;
  end

  // R9: multiplying by the field identity returns the other factor.
  always_comb begin
    if (b_i == LW'(1)) begin
      assert_gf_identity_R9: assert (p_o == a_i);
    end
  end

endmodule

// File: rtl/simd_mul_cplx.sv
module simd_mul_cplx #(
  parameter int unsigned HW = 16
) (
  input  logic [2*HW-1:0] a_i,
  input  logic [2*HW-1:0] b_i,
  output logic [4*HW-1:0] full_o,
  output logic [2*HW-1:0] rnd_o
);

  localparam int unsigned PW = 2*HW;
  localparam int unsigned XW = 2*HW + 1;
  localparam logic signed [XW-1:0] SAT_MAX = XW'((1 << (HW-1)) - 1);
  localparam logic signed [XW-1:0] SAT_MIN = -XW'(1 << (HW-1));
  localparam logic signed [XW-1:0] HALF    = XW'(1 << (HW-1));

  logic signed [HW-1:0] ar, ai, br, bi;
  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
  logic signed [XW-1:0] re_x, im_x;

  function automatic logic [HW-1:0] round_sat(input logic signed [XW-1:0] v);
    logic signed [XW-1:0] t;
    t = (v + HALF) >>> HW;
    if (t > SAT_MAX)      round_sat = SAT_MAX[HW-1:0];
    else if (t < SAT_MIN) round_sat = SAT_MIN[HW-1:0];
    else                  round_sat = t[HW-1:0];
  endfunction

  always_comb begin
    ar   = $signed(a_i[PW-1:HW]);
    ai   = $signed(a_i[HW-1:0]);
    br   = $signed(b_i[PW-1:HW]);
    bi   = $signed(b_i[HW-1:0]);
    p_rr = PW'(ar) * PW'(br);
    p_ii = PW'(ai) * PW'(bi);
    p_ri = PW'(ar) * PW'(bi);
    p_ir = PW'(ai) * PW'(br);
    re_x = XW'(p_rr) - XW'(p_ii);
    im_x = XW'(p_ri) + XW'(p_ir);
    full_o = {re_x[PW-1:0], im_x[PW-1:0]};
    rnd_o  = {round_sat(re_x), round_sat(im_x)};
  end

endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit
  import simd_mul_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [OP_W-1:0]      in_op,
  input  logic [DW-1:0]        in_a,
  input  logic [DW-1:0]        in_b,
  input  logic                 poly_we,
  input  logic [GF_W-1:0]      poly_wdata,
  output logic                 out_valid,
  output logic [2*DW-1:0]      out_res
);

  localparam int unsigned RW  = 2*DW;
  localparam int unsigned HW  = DW/2;
  localparam int unsigned NB  = DW/8;
  localparam int unsigned N16 = 2;

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // ---------------- polynomial register ----------------
  logic [GF_W-1:0] poly_q, poly_d;

  always_comb poly_d = poly_we ? poly_wdata : poly_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) poly_q <= GF_POLY_RESET;
    else             poly_q <= poly_d;
  end

  // ---------------- stage 1: operand capture ----------------
  logic            s1_valid_q;
  logic [OP_W-1:0] s1_op_q, s1_op_d;
  logic [DW-1:0]   s1_a_q, s1_a_d, s1_b_q, s1_b_d;
  logic [GF_W-1:0] s1_poly_q, s1_poly_d;
  logic            s1_en;

  always_comb begin
    s1_en     = in_valid;
    s1_op_d   = s1_en ? in_op   : s1_op_q;
    s1_a_d    = s1_en ? in_a    : s1_a_q;
    s1_b_d    = s1_en ? in_b    : s1_b_q;
    s1_poly_d = s1_en ? poly_q  : s1_poly_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_valid_q <= 1'b0;
      s1_op_q    <= '0;
      s1_a_q     <= '0;
      s1_b_q     <= '0;
      s1_poly_q  <= '0;
    end else begin
      s1_valid_q <= in_valid;
      s1_op_q    <= s1_op_d;
      s1_a_q     <= s1_a_d;
      s1_b_q     <= s1_b_d;
      s1_poly_q  <= s1_poly_d;
    end
  end

  // ---------------- stage 2: compute ----------------
  // full-width product with per-operand sign selection
  logic              sa, sb;
  logic signed [DW:0] ax, bx;
  logic [RW-1:0]     mul_res;

  always_comb begin
    sa = (s1_op_q == OP_MUL_SS) || (s1_op_q == OP_MUL_SU);
    sb = (s1_op_q == OP_MUL_SS);
    ax = $signed({sa & s1_a_q[DW-1], s1_a_q});
    bx = $signed({sb & s1_b_q[DW-1], s1_b_q});
    mul_res = RW'(ax) * RW'(bx);
  end

  // signed 16-bit lanes
  logic signed [DW-1:0] p16 [N16];
  for (genvar k = 0; k < N16; k++) begin : g_l16
    always_comb p16[k] = DW'($signed(s1_a_q[k*HW +: HW])) * DW'($signed(s1_b_q[k*HW +: HW]));
  end

  // unsigned byte lanes and GF lanes
  logic [HW-1:0]   p8  [NB];
  logic [GF_W-1:0] pgf [NB];
  for (genvar k = 0; k < NB; k++) begin : g_l8
    always_comb p8[k] = HW'(s1_a_q[k*8 +: 8]) * HW'(s1_b_q[k*8 +: 8]);
    simd_mul_gf8 #(.LW(GF_W)) i_gf (
      .a_i    (s1_a_q[k*8 +: 8]),
      .b_i    (s1_b_q[k*8 +: 8]),
      .poly_i (s1_poly_q),
      .p_o    (pgf[k])
    );
  end

  logic [RW-1:0] cplx_full;
  logic [DW-1:0] cplx_rnd;

  simd_mul_cplx #(.HW(HW)) i_cplx (
    .a_i    (s1_a_q),
    .b_i    (s1_b_q),
    .full_o (cplx_full),
    .rnd_o  (cplx_rnd)
  );

  logic signed [DW:0] dot16_add, dot16_sub;
  logic [DW-1:0]      dot8_sum;
  logic [RW-1:0]      quad8_res;
  logic [DW-1:0]      gf_res;

  always_comb begin
    dot16_add = (DW+1)'(p16[1]) + (DW+1)'(p16[0]);
    dot16_sub = (DW+1)'(p16[1]) - (DW+1)'(p16[0]);
    dot8_sum  = '0;
    for (int k = 0; k < NB; k++) begin
      dot8_sum              = dot8_sum + DW'(p8[k]);
      quad8_res[k*HW +: HW] = p8[k];
      gf_res[k*8 +: 8]      = pgf[k];
    end
  end

  logic [RW-1:0] res_sel;

  always_comb begin
    case (s1_op_q)
      OP_MUL_SS, OP_MUL_UU, OP_MUL_SU: res_sel = mul_res;
      OP_DUAL16:    res_sel = {p16[1], p16[0]};
      OP_DOT16_ADD: res_sel = {{(RW-DW-1){dot16_add[DW]}}, dot16_add};
      OP_DOT16_SUB: res_sel = {{(RW-DW-1){dot16_sub[DW]}}, dot16_sub};
      OP_QUAD8:     res_sel = quad8_res;
      OP_DOT8:      res_sel = {{DW{1'b0}}, dot8_sum};
      OP_CMPY:      res_sel = cplx_full;
      OP_CMPY_RND:  res_sel = {{DW{1'b0}}, cplx_rnd};
      OP_GF8:       res_sel = {{DW{1'b0}}, gf_res};
      default:      res_sel = '0;
    endcase
  end

  // ---------------- stage 2 register ----------------
  logic          out_en;
  logic [RW-1:0] out_res_d;

  always_comb begin
    out_en    = s1_valid_q;
    out_res_d = out_en ? res_sel : out_res;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else begin
      out_valid <= s1_valid_q;
      out_res   <= out_res_d;
    end
  end

  // ---------------- assertions ----------------
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> ##1 out_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> ##1 !out_valid);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !s1_valid_q |=> $stable(out_res));

  assert_poly_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !poly_we |=> $stable(poly_q));

endmodule

// File: tb/test_simd_mul_unit.sv
module test_simd_mul_unit;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [31:0] in_a, in_b;
  logic        poly_we;
  logic [7:0]  poly_wdata;
  logic        out_valid;
  logic [63:0] out_res;

  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] tb_poly = 8'h1D;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_mul_unit i_simd_mul_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .poly_we(poly_we), .poly_wdata(poly_wdata),
    .out_valid(out_valid), .out_res(out_res)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------- reference models ----------
  function automatic logic [63:0] ref_mul(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, ua, ub;
    sa = longint'($signed(a));
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    case (op)
      4'd0: return sa * longint'($signed(b));
      4'd1: return ua * ub;
      default: return sa * ub;
    endcase
  endfunction

  function automatic longint slane(input logic [31:0] x, input int hi);
    return hi ? longint'($signed(x[31:16])) : longint'($signed(x[15:0]));
  endfunction

  function automatic logic [15:0] rsat(input longint v);
    longint t;
    t = (v + 32768) >>> 16;
    if (t > 32767) return 16'h7FFF;
    if (t < -32768) return 16'h8000;
    return t[15:0];
  endfunction

  function automatic logic [7:0] ref_gf(input logic [7:0] a, input logic [7:0] b, input logic [7:0] poly);
    logic [15:0] cl;
    cl = '0;
    for (int i = 0; i < 8; i++) if (b[i]) cl = cl ^ (16'(a) << i);
    for (int k = 15; k >= 8; k--) if (cl[k]) cl = cl ^ ({7'b0, 1'b1, poly} << (k-8));
    return cl[7:0];
  endfunction

  // Issue one operation and check its result and timing.
  task automatic run_op(input string tag, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R1 not yet valid"}, {63'b0, out_valid}, 64'd0);
    @(negedge clk);
    check({tag, " R1 valid"}, {63'b0, out_valid}, 64'd1);
    check(tag, out_res, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0;
    poly_we = 1'b0; poly_wdata = '0;
    repeat (3) @(negedge clk);
    check("R11 valid in reset", {63'b0, out_valid}, 64'd0);
    check("R11 result in reset", out_res, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 valid after reset", {63'b0, out_valid}, 64'd0);
    check("R11 result after reset", out_res, 64'd0);
  endtask

  task automatic t_mul32;
    logic [31:0] a, b;
    a = 32'hFFFF_FFFE; b = 32'h8000_0000;
    run_op("R2 signed", 4'd0, a, b, ref_mul(4'd0, a, b));
    run_op("R2 unsigned", 4'd1, a, b, ref_mul(4'd1, a, b));
    run_op("R2 mixed", 4'd2, a, b, ref_mul(4'd2, a, b));
    a = 32'h1234_5678; b = 32'hFEDC_BA98;
    run_op("R2 signed b", 4'd0, a, b, ref_mul(4'd0, a, b));
  endtask

  task automatic t_dual16;
    logic [31:0] a, b;
    longint lo, hi;
    a = 32'h8000_7FFF; b = 32'h8000_FFFD;
    lo = slane(a, 0) * slane(b, 0);
    hi = slane(a, 1) * slane(b, 1);
    run_op("R3 dual", 4'd3, a, b, {hi[31:0], lo[31:0]});
    run_op("R4 dot add", 4'd4, a, b, 64'(hi + lo));
    run_op("R4 dot sub", 4'd5, a, b, 64'(hi - lo));
    a = 32'h8000_8000; b = 32'h8000_8000;
    run_op("R4 dot add max", 4'd4, a, b, 64'h0000_0000_8000_0000);
  endtask

  task automatic t_bytes;
    logic [31:0] a, b;
    logic [63:0] q;
    longint s;
    a = 32'hFF02_7F10; b = 32'hFF80_0305;
    s = 0;
    for (int k = 0; k < 4; k++) begin
      q[k*16 +: 16] = 16'(a[k*8 +: 8]) * 16'(b[k*8 +: 8]);
      s = s + longint'(a[k*8 +: 8]) * longint'(b[k*8 +: 8]);
    end
    run_op("R5 quad", 4'd6, a, b, q);
    run_op("R6 dot8", 4'd7, a, b, 64'(s));
  endtask

  task automatic t_cmpy;
    logic [31:0] a, b;
    longint re, im;
    a = 32'h0003_FFFE; b = 32'h0005_0007;
    re = slane(a, 1) * slane(b, 1) - slane(a, 0) * slane(b, 0);
    im = slane(a, 1) * slane(b, 0) + slane(a, 0) * slane(b, 1);
    run_op("R7 cmpy", 4'd8, a, b, {re[31:0], im[31:0]});
    run_op("R8 cmpy rnd small", 4'd9, a, b, {32'b0, rsat(re), rsat(im)});
    a = 32'h4000_C000; b = 32'h2000_3000;
    re = slane(a, 1) * slane(b, 1) - slane(a, 0) * slane(b, 0);
    im = slane(a, 1) * slane(b, 0) + slane(a, 0) * slane(b, 1);
    run_op("R8 cmpy rnd mid", 4'd9, a, b, {32'b0, rsat(re), rsat(im)});
    a = 32'h8000_8000; b = 32'h8000_8000;
    run_op("R7 cmpy wrap", 4'd8, a, b, 64'h0000_0000_8000_0000);
    run_op("R8 cmpy saturate", 4'd9, a, b, 64'h0000_0000_0000_7FFF);
  endtask

  task automatic t_gf;
    logic [31:0] a, b, q;
    a = 32'h5302_0701; b = 32'hCA80_09A5;
    for (int k = 0; k < 4; k++) q[k*8 +: 8] = ref_gf(a[k*8 +: 8], b[k*8 +: 8], tb_poly);
    run_op("R9 gf reset poly", 4'd10, a, b, {32'b0, q});
    @(negedge clk);
    poly_we = 1'b1; poly_wdata = 8'h1B;
    @(negedge clk);
    poly_we = 1'b0; poly_wdata = 8'h00;
    tb_poly = 8'h1B;
    for (int k = 0; k < 4; k++) q[k*8 +: 8] = ref_gf(a[k*8 +: 8], b[k*8 +: 8], tb_poly);
    run_op("R9 gf written poly", 4'd10, a, b, {32'b0, q});
    check("R9 gf known product", {56'b0, q[31:24]}, 64'h01);
  endtask

  task automatic t_unused_and_hold;
    logic [63:0] last;
    run_op("R10 unused op", 4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0);
    run_op("R10 setup", 4'd1, 32'h0000_1234, 32'h0000_0100, 64'h0012_3400);
    last = out_res;
    @(negedge clk);
    in_op = 4'd0; in_a = 32'hDEAD_BEEF; in_b = 32'hCAFE_F00D;
    repeat (3) @(negedge clk);
    check("R10 hold result", out_res, last);
    check("R1 idle no valid", {63'b0, out_valid}, 64'd0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_valid = 1'b1; in_op = 4'd1; in_a = 32'd3; in_b = 32'd5;
    @(negedge clk);
    in_a = 32'd7; in_b = 32'd11;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 b2b first valid", {63'b0, out_valid}, 64'd1);
    check("R1 b2b first", out_res, 64'd15);
    @(negedge clk);
    check("R1 b2b second valid", {63'b0, out_valid}, 64'd1);
    check("R1 b2b second", out_res, 64'd77);
    @(negedge clk);
    check("R1 b2b drain", {63'b0, out_valid}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_mul32();
    t_dual16();
    t_bytes();
    t_cmpy();
    t_gf();
    t_unused_and_hold();
    t_back_to_back();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule